// File: doc/BRIEF.md
# Health Test Alert Aggregator

This block sits behind a bank of nine statistical health tests that watch a raw noise source. At the end of each test window the tests report which of them failed. The block keeps a small saturating failure count per test and a 16-bit total of those counts. It raises a recoverable alert once the total reaches a programmed threshold. A window with no failure at all wipes every count. Once an alert fires, the counts are frozen as evidence until an explicit clear.

The threshold is held in a configuration word with a redundant copy. The low half is the threshold and the high half must be its bitwise inverse. Any mismatch sets a sticky configuration-error flag and blocks alerting. A threshold of zero turns alerting off. All pins are plain control and status signals sampled on the clock. No data stream passes through the block, so it has no valid/ready interface and applies no back-pressure.

Top module: `ht_alert_agg`

## Requirements
- R1: After reset all counts and the total read zero, `alert_o`, `hf_irq_o` and `cfg_err_o` are low, and the stored configuration word is 0xFFFD_0002 (threshold 2).
- R2: On a cycle with `win_done_i` high and at least one bit of `fail_i` set, each count whose `fail_i` bit is set rises by one. Bit i maps to count i in `counts_o[4i+3:4i]`. The test order is: 0 repetition, 1 repetition-symbol, 2 proportion-high, 3 proportion-low, 4 bucket, 5 Markov-high, 6 Markov-low, 7 external-high, 8 external-low. The updated counts are visible in the following cycle.
- R3: A count that is at 15 stays at 15 on further failures and does not wrap.
- R4: `total_o` always equals the sum of the nine counts, in the same cycle.
- R5: A cycle with `win_done_i` high and `fail_i` all zero clears every count to zero, unless the block is alerted.
- R6: When the configuration is consistent, the threshold is nonzero and `total_o >= threshold`, `alert_o` pulses high for exactly one cycle, one cycle after the total first reaches the threshold. `hf_irq_o` rises in that same cycle and stays high until a clear.
- R7: While `hf_irq_o` is high, window results (passing or failing) leave all counts unchanged.
- R8: A threshold of zero never produces an alert, whatever the total.
- R9: If bits 31:16 of the stored word differ from the bitwise inverse of bits 15:0, `cfg_err_o` goes high one cycle after the word is stored and stays high until a clear. No alert is raised while the stored word is inconsistent.
- R10: `clear_i` zeroes all counts, `hf_irq_o` and `cfg_err_o` in the following cycle. It takes priority over a simultaneous window result. If the stored word is still inconsistent, `cfg_err_o` sets again one cycle later.
- R11: `cfg_load_i` stores `cfg_word_i` as the new configuration word, and the new threshold governs alerting from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fail_i | input | 9 | Per-test failure flags for the window that is ending |
| win_done_i | input | 1 | Window-complete strobe; qualifies `fail_i` |
| cfg_load_i | input | 1 | Store `cfg_word_i` |
| cfg_word_i | input | 32 | Threshold in 15:0, its inverse in 31:16 |
| clear_i | input | 1 | Clear counts, alerted state and configuration error |
| counts_o | output | 36 | Nine 4-bit per-test failure counts, test 0 in bits 3:0 |
| total_o | output | 16 | Sum of the nine counts |
| alert_o | output | 1 | One-cycle recoverable alert pulse |
| hf_irq_o | output | 1 | Health-failed interrupt request, level |
| cfg_err_o | output | 1 | Sticky configuration-consistency error |

## Verification
The assertions watch these properties on every cycle:
- no count wraps past 15;
- every count holds still while the block is alerted or about to alert;
- the alert is a single-cycle pulse that comes with the interrupt;
- no alert appears under a zero or inconsistent threshold;
- the configuration error stays set until a clear.

Only the directed scenarios can show the following:
- the test-to-field mapping;
- the exact total for a given failure mix;
- the zeroing done by a passing window;
- the reset threshold of 2;
- the cycle in which the alert fires;
- the ordering of clear against a simultaneous window;
- the configuration error setting again after a clear while the stored word is still bad.

// File: rtl/ht_agg_pkg.sv
package ht_agg_pkg;

  localparam int unsigned HT_NUM_TESTS = 9;
  localparam int unsigned HT_CNT_W     = 4;
  localparam int unsigned HT_THR_W     = 16;

  // Bit position of each test in the fail vector and count bus
  typedef enum logic [3:0] {
    HT_REP     = 4'd0,
    HT_REP_SYM = 4'd1,
    HT_ADP_HI  = 4'd2,
    HT_ADP_LO  = 4'd3,
    HT_BUCKET  = 4'd4,
    HT_MKV_HI  = 4'd5,
    HT_MKV_LO  = 4'd6,
    HT_EXT_HI  = 4'd7,
    HT_EXT_LO  = 4'd8
  } ht_test_e;

  // Redundant threshold word: value low, inverse high
  typedef struct packed {
    logic [HT_THR_W-1:0] inv;
    logic [HT_THR_W-1:0] val;
  } ht_thr_cfg_t;

endpackage

// File: rtl/ht_fail_counter.sv
module ht_fail_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             freeze_i,
  input  logic             win_i,
  input  logic             pass_all_i,
  input  logic             fail_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (win_i && !freeze_i) begin
      if (pass_all_i) begin
        cnt_d = '0;
      end else if (fail_i && (cnt_q != CntMax)) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R3: a saturated count never wraps back to a small value
  assert_no_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CntMax && !clr_i && !(win_i && pass_all_i)) |=> (cnt_q == CntMax));

  // R7: frozen counts do not move unless cleared
  assert_frozen_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/ht_sum_tree.sv
module ht_sum_tree #(
  parameter int unsigned NUM   = 9,
  parameter int unsigned CNT_W = 4,
  parameter int unsigned TOT_W = 16
) (
  input  logic [NUM*CNT_W-1:0] cnts_i,
  output logic [TOT_W-1:0]     total_o
);

  always_comb begin
    total_o = '0;
    for (int i = 0; i < NUM; i++) begin
      total_o = total_o + TOT_W'(cnts_i[i*CNT_W +: CNT_W]);
    end
  end

endmodule

// File: rtl/ht_thr_store.sv
module ht_thr_store #(
  parameter int unsigned    THR_W   = 16,
  parameter logic [THR_W-1:0] THR_RST = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [2*THR_W-1:0] word_i,
  input  logic               clr_i,
  output logic [THR_W-1:0]   thr_o,
  output logic               cfg_ok_o,
  output logic               cfg_err_o
);

  logic [THR_W-1:0] val_q, inv_q;
  logic             err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= THR_RST;
      inv_q <= ~THR_RST;
    end else if (load_i) begin
      val_q <= word_i[THR_W-1:0];
      inv_q <= word_i[2*THR_W-1:THR_W];
    end
  end

  assign cfg_ok_o = (inv_q == ~val_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     err_q <= 1'b0;
    else if (clr_i)  err_q <= 1'b0;
    else             err_q <= err_q | ~cfg_ok_o;
  end

  assign thr_o     = val_q;
  assign cfg_err_o = err_q;

  // R9: the error flag is sticky until a clear
  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !clr_i) |=> err_q);

  // R10: a clear drops the flag on the next cycle
  assert_err_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !err_q);

endmodule

// File: rtl/ht_alert_ctrl.sv
module ht_alert_ctrl #(
  parameter int unsigned TOT_W = 16,
  parameter int unsigned THR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TOT_W-1:0] total_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             cfg_ok_i,
  input  logic             clr_i,
  output logic             freeze_o,
  output logic             alert_o,
  output logic             alerted_o
);

  localparam int unsigned CmpW = (TOT_W > THR_W) ? TOT_W : THR_W;

  logic [CmpW-1:0] tot_ext, thr_ext;
  logic            trip;
  logic            alerted_q, pulse_q;

  assign tot_ext = CmpW'(total_i);
  assign thr_ext = CmpW'(thr_i);
  assign trip    = cfg_ok_i && (thr_i != '0) && (tot_ext >= thr_ext);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alerted_q <= 1'b0;
      pulse_q   <= 1'b0;
    end else if (clr_i) begin
      alerted_q <= 1'b0;
      pulse_q   <= 1'b0;
    end else begin
      alerted_q <= alerted_q | trip;
      pulse_q   <= trip & ~alerted_q;
    end
  end

  assign freeze_o  = alerted_q | trip;
  assign alert_o   = pulse_q;
  assign alerted_o = alerted_q;

  // R6: the alert lasts one cycle and comes with the interrupt
  assert_alert_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);
  assert_alert_irq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> alerted_q);

  // R8: zero threshold never alerts
  assert_zero_thr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_i == '0 && !alerted_q) |=> !pulse_q);

  // R9: inconsistent configuration never alerts
  assert_bad_cfg_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_ok_i && !alerted_q) |=> !pulse_q);

endmodule

// File: rtl/ht_alert_agg.sv
module ht_alert_agg
  import ht_agg_pkg::*;
#(
  parameter int unsigned NUM_TESTS = HT_NUM_TESTS,
  parameter int unsigned CNT_W     = HT_CNT_W,
  parameter int unsigned TOT_W     = 16,
  parameter int unsigned THR_W     = HT_THR_W,
  parameter logic [THR_W-1:0] THR_RST = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_TESTS-1:0]     fail_i,
  input  logic                     win_done_i,
  input  logic                     cfg_load_i,
  input  logic [2*THR_W-1:0]       cfg_word_i,
  input  logic                     clear_i,
  output logic [NUM_TESTS*CNT_W-1:0] counts_o,
  output logic [TOT_W-1:0]         total_o,
  output logic                     alert_o,
  output logic                     hf_irq_o,
  output logic                     cfg_err_o
);

  logic               pass_all;
  logic               freeze;
  logic [THR_W-1:0]   thr;
  logic               cfg_ok;
  logic [NUM_TESTS*CNT_W-1:0] cnts;

  assign pass_all = ~|fail_i;

  for (genvar g = 0; g < NUM_TESTS; g++) begin : g_cnt
    ht_fail_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (clear_i),
      .freeze_i   (freeze),
      .win_i      (win_done_i),
      .pass_all_i (pass_all),
      .fail_i     (fail_i[g]),
      .cnt_o      (cnts[g*CNT_W +: CNT_W])
    );
  end

  ht_sum_tree #(.NUM(NUM_TESTS), .CNT_W(CNT_W), .TOT_W(TOT_W)) u_sum (
    .cnts_i  (cnts),
    .total_o (total_o)
  );

  ht_thr_store #(.THR_W(THR_W), .THR_RST(THR_RST)) u_thr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (cfg_load_i),
    .word_i    (cfg_word_i),
    .clr_i     (clear_i),
    .thr_o     (thr),
    .cfg_ok_o  (cfg_ok),
    .cfg_err_o (cfg_err_o)
  );

  ht_alert_ctrl #(.TOT_W(TOT_W), .THR_W(THR_W)) u_alert (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .total_i   (total_o),
    .thr_i     (thr),
    .cfg_ok_i  (cfg_ok),
    .clr_i     (clear_i),
    .freeze_o  (freeze),
    .alert_o   (alert_o),
    .alerted_o (hf_irq_o)
  );

  assign counts_o = cnts;

  // R10: clear empties every count and drops the interrupt
  assert_clear_empties_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (counts_o == '0 && !hf_irq_o));

  // R7: window results are ignored once alerted
  assert_irq_freeze_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hf_irq_o && !clear_i) |=> $stable(counts_o));

endmodule

// File: tb/ht_alert_agg_test.sv
module ht_alert_agg_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  fail = '0;
  logic        win = 1'b0;
  logic        load = 1'b0;
  logic [31:0] word = '0;
  logic        clr = 1'b0;
  logic [35:0] counts;
  logic [15:0] total;
  logic        alert, irq, cfg_err;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  ht_alert_agg uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .fail_i     (fail),
    .win_done_i (win),
    .cfg_load_i (load),
    .cfg_word_i (word),
    .clear_i    (clr),
    .counts_o   (counts),
    .total_o    (total),
    .alert_o    (alert),
    .hf_irq_o   (irq),
    .cfg_err_o  (cfg_err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic window(input logic [8:0] f);
    @(negedge clk); fail = f; win = 1'b1;
    @(negedge clk); win = 1'b0; fail = '0;
  endtask

  task automatic cfg(input logic [31:0] w);
    @(negedge clk); load = 1'b1; word = w;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 counts", 64'(counts), 0);
    chk("R1 total", 64'(total), 0);
    chk("R1 alert", 64'(alert), 0);
    chk("R1 irq", 64'(irq), 0);
    chk("R1 cfg_err", 64'(cfg_err), 0);
  endtask

  task automatic t_default_thr();
    window(9'h001);
    chk("R2 one fail", 64'(counts), 64'h1);
    idle();
    chk("R1 below default threshold", 64'(alert), 0);
    window(9'h002);
    chk("R4 total two", 64'(total), 2);
    idle();
    chk("R1 default threshold alert", 64'(alert), 1);
    chk("R6 irq with alert", 64'(irq), 1);
    idle();
    chk("R6 one-cycle alert", 64'(alert), 0);
    chk("R6 irq level", 64'(irq), 1);
    do_clear();
    chk("R10 counts cleared", 64'(counts), 0);
    chk("R10 irq cleared", 64'(irq), 0);
  endtask

  task automatic t_count();
    cfg(32'hFFEB_0014);
    window(9'h1FF);
    chk("R2 all tests", 64'(counts), 64'h1_1111_1111);
    chk("R4 total nine", 64'(total), 9);
    window(9'b1_0000_0100);
    chk("R2 field map", 64'(counts), 64'h2_1111_1211);
    chk("R4 total eleven", 64'(total), 11);
    window(9'h000);
    chk("R5 pass zeroes", 64'(counts), 0);
    chk("R5 total zero", 64'(total), 0);
  endtask

  task automatic t_sat();
    cfg(32'hFFFF_0000);
    for (int i = 0; i < 18; i++) window(9'h020);
    chk("R3 saturate", 64'(counts), 64'h0_00F0_0000);
    chk("R4 total sat", 64'(total), 15);
    idle();
    chk("R8 zero threshold alert", 64'(alert), 0);
    chk("R8 zero threshold irq", 64'(irq), 0);
    window(9'h000);
    chk("R5 pass after sat", 64'(counts), 0);
  endtask

  task automatic t_alert();
    cfg(32'hFFFC_0003);
    window(9'h003);
    idle();
    chk("R6 below threshold", 64'(alert), 0);
    window(9'h010);
    chk("R4 total three", 64'(total), 3);
    idle();
    chk("R6 alert fires", 64'(alert), 1);
    chk("R6 irq fires", 64'(irq), 1);
    idle();
    chk("R6 alert drops", 64'(alert), 0);
    window(9'h000);
    chk("R7 pass ignored", 64'(counts), 64'h0_0001_0011);
    window(9'h040);
    chk("R7 fail ignored", 64'(counts), 64'h0_0001_0011);
    chk("R7 irq held", 64'(irq), 1);
    @(negedge clk); clr = 1'b1; win = 1'b1; fail = 9'h1FF;
    @(negedge clk); clr = 1'b0; win = 1'b0; fail = '0;
    chk("R10 clear beats window", 64'(counts), 0);
    chk("R10 irq cleared", 64'(irq), 0);
  endtask

  task automatic t_cfg();
    cfg(32'h0000_0003);
    idle();
    chk("R9 mismatch flagged", 64'(cfg_err), 1);
    window(9'h007);
    idle(); idle();
    chk("R9 alert suppressed", 64'(alert), 0);
    chk("R9 irq suppressed", 64'(irq), 0);
    window(9'h001);
    chk("R9 counting continues", 64'(total), 4);
    do_clear();
    chk("R10 cfg_err cleared", 64'(cfg_err), 0);
    idle();
    chk("R10 cfg_err resets", 64'(cfg_err), 1);
    cfg(32'hFFFC_0003);
    idle();
    chk("R9 sticky after fix", 64'(cfg_err), 1);
    do_clear();
    idle();
    chk("R9 stays clear", 64'(cfg_err), 0);
    window(9'h007);
    idle();
    chk("R11 new threshold alerts", 64'(alert), 1);
    do_clear();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    t_reset();
    t_default_thr();
    t_count();
    t_sat();
    t_alert();
    t_cfg();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule